// File: doc/BRIEF.md
# FPGA Frame Configuration Loader

This block configures an SRAM-based FPGA over a byte-wide write port. On a start request it pulses the target's active-low program pin, waits for the target's active-low init pin to rise, and writes a fixed eight-byte header. It then reads configuration bytes from a valid/ready stream and wraps each group of 21 bytes into a record. The record opens with a preamble byte and closes with a check code and padding writes. When no more records can be sent, it writes four startup bytes and reports success or failure.

Every byte goes out on the dedicated programming write port as a one-cycle strobe. Consecutive strobes always have an idle cycle between them. The write port never serves functional registers, so extra strobes at the end of configuration are harmless. The stream is only drawn on while a payload byte is due, so the source can stall freely. Storing the bitstream and producing its contents belong to the surrounding system.

Top module: `fpga_frame_loader`

## Requirements
- R1: After reset, prog_no is high, wr_strobe_o and s_ready_o are low, and busy_o, done_o and error_o are low.
- R2: A start with a payload_len_i that is not a multiple of 21 sets error_o on the next cycle. It produces no program pulse and no writes, and busy_o stays low.
- R3: A valid start drives prog_no low for exactly PROG_HOLD_CYC cycles, after which it returns high.
- R4: No write happens while prog_no is low or before init_ni reads high. If init_ni stays low for INIT_TMO_CYC cycles, the load ends with error_o set, prog_no high and no write issued.
- R5: The first eight writes are 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B, in that order.
- R6: Each record is 0x4F, then 21 stream bytes in stream order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF. A stream byte is taken only on a cycle where both s_valid_i and s_ready_o are high.
- R7: A record starts only if init_ni is high, done_i is low and payload bytes remain. Otherwise the loader goes straight to the startup bytes.
- R8: After the last record, or when the record loop ends early, exactly four 0xFF bytes are written.
- R9: At the end of a load, done_o is set if every payload byte was consumed and done_i is high. Otherwise error_o is set. The two flags are never high together, and both clear on the next start.
- R10: wr_strobe_o is high for one cycle per byte and is always followed by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (taken while idle) |
| payload_len_i | input | LEN_W | Total payload bytes, a multiple of 21 |
| s_data_i | input | 8 | Configuration stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Loader accepts a stream byte this cycle |
| init_ni | input | 1 | Target init pin, low while not ready |
| done_i | input | 1 | Target configuration-complete pin |
| prog_no | output | 1 | Target program pin, low resets the target |
| wr_data_o | output | 8 | Byte on the programming write port |
| wr_strobe_o | output | 1 | One-cycle write strobe |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| error_o | output | 1 | Last load failed or was rejected |

## Verification
The assertions assume that start_i is only meaningful while busy_o is low. They also assume that the target pins behave like a real device: init_ni is held low while prog_no is low, and done_i is low at the start of each load. The bench's target model pulls both pins low for the whole program pulse. It raises init_ni a few cycles after release and raises done_i only at a chosen write count. It drops init_ni at a record boundary, or never raises it, only in the tests that probe early exit and timeout.

// File: rtl/fpga_ld_pkg.sv
package fpga_ld_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_WINIT, ST_HDR, ST_CHK,
    ST_PRE, ST_PAY, ST_TRL, ST_STUP, ST_FIN
  } ld_state_e;

  localparam int HDR_LEN  = 8;
  localparam int TRL_LEN  = 6;
  localparam int STUP_LEN = 4;

  localparam logic [7:0] PREAMBLE   = 8'h4F;
  localparam logic [7:0] CHECK_CODE = 8'h4B;
  localparam logic [7:0] FILL       = 8'hFF;

  function automatic logic [7:0] hdr_byte(input logic [2:0] i);
    case (i)
      3'd3:    hdr_byte = PREAMBLE;
      3'd4:    hdr_byte = 8'h80;
      3'd5:    hdr_byte = 8'hAF;
      3'd6:    hdr_byte = 8'h9B;
      3'd7:    hdr_byte = CHECK_CODE;
      default: hdr_byte = FILL;
    endcase
  endfunction

  function automatic logic [7:0] trl_byte(input logic [2:0] i);
    trl_byte = (i == 3'd0 || i == 3'd2) ? CHECK_CODE : FILL;
  endfunction
endpackage

// File: rtl/fpga_ld_timer.sv
module fpga_ld_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fpga_ld_wr_port.sv
// Registered write port: one-cycle strobe, never two in a row.
module fpga_ld_wr_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       strobe_o,
  output logic [7:0] data_o
);
  logic       stb_q;
  logic [7:0] dat_q;

  assign ready_o = !stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      dat_q <= '0;
    end else begin
      stb_q <= req_i && !stb_q;
      if (req_i && !stb_q) dat_q <= data_i;
    end
  end

  assign strobe_o = stb_q;
  assign data_o   = dat_q;
endmodule

// File: rtl/fpga_frame_loader.sv
module fpga_frame_loader
  import fpga_ld_pkg::*;
#(
  parameter int LEN_W         = 20,
  parameter int FRAME_BYTES   = 21,
  parameter int PROG_HOLD_CYC = 2000,     // 10 us at 200 MHz
  parameter int INIT_TMO_CYC  = 1000000   // 5 ms at 200 MHz
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] payload_len_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic             init_ni,
  input  logic             done_i,
  output logic             prog_no,
  output logic [7:0]       wr_data_o,
  output logic             wr_strobe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  localparam int TMR_MAX = (PROG_HOLD_CYC > INIT_TMO_CYC) ? PROG_HOLD_CYC : INIT_TMO_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int IDX_W   = $clog2(FRAME_BYTES);

  ld_state_e          state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [LEN_W-1:0]   rem_q, rem_d;
  logic               done_q, done_d, error_q, error_d;
  logic               tmr_load, tmr_exp;
  logic [TMR_W-1:0]   tmr_val;
  logic               em_req, em_ready, acc;
  logic [7:0]         em_data;
  logic               len_ok;

  assign len_ok = (payload_len_i % LEN_W'(FRAME_BYTES)) == '0;
  assign acc    = em_req && em_ready;

  fpga_ld_timer #(.W(TMR_W)) tmr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  fpga_ld_wr_port wr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (em_req),
    .data_i   (em_data),
    .ready_o  (em_ready),
    .strobe_o (wr_strobe_o),
    .data_o   (wr_data_o)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rem_d    = rem_q;
    done_d   = done_q;
    error_d  = error_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    em_req   = 1'b0;
    em_data  = FILL;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        done_d = 1'b0;
        if (!len_ok) error_d = 1'b1;
        else begin
          error_d  = 1'b0;
          rem_d    = payload_len_i;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PROG_HOLD_CYC - 1);
          state_d  = ST_PROG;
        end
      end
      ST_PROG: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(INIT_TMO_CYC - 1);
        state_d  = ST_WINIT;
      end
      ST_WINIT: begin
        if (init_ni) begin
          idx_d   = '0;
          state_d = ST_HDR;
        end else if (tmr_exp) begin
          error_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_HDR: begin
        em_req  = 1'b1;
        em_data = hdr_byte(idx_q[2:0]);
        if (acc) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(HDR_LEN - 1)) begin
            idx_d   = '0;
            state_d = ST_CHK;
          end
        end
      end
      ST_CHK: begin
        idx_d   = '0;
        state_d = (init_ni && !done_i && rem_q != '0) ? ST_PRE : ST_STUP;
      end
      ST_PRE: begin
        em_req  = 1'b1;
        em_data = PREAMBLE;
        if (acc) state_d = ST_PAY;
      end
      ST_PAY: begin
        em_req  = s_valid_i;
        em_data = s_data_i;
        if (acc) begin
          rem_d = rem_q - 1'b1;
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(FRAME_BYTES - 1)) begin
            idx_d   = '0;
            state_d = ST_TRL;
          end
        end
      end
      ST_TRL: begin
        em_req  = 1'b1;
        em_data = trl_byte(idx_q[2:0]);
        if (acc) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(TRL_LEN - 1)) state_d = ST_CHK;
        end
      end
      ST_STUP: begin
        em_req = 1'b1;
        if (acc) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(STUP_LEN - 1)) state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        if (rem_q == '0 && done_i) done_d  = 1'b1;
        else                       error_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
      error_q <= error_d;
    end
  end

  assign s_ready_o = (state_q == ST_PAY) && em_ready;
  assign prog_no   = (state_q != ST_PROG);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign error_o   = error_q;
endmodule

// File: rtl/fpga_frame_loader_chk.sv
module fpga_frame_loader_chk #(
  parameter int LEN_W       = 20,
  parameter int FRAME_BYTES = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] payload_len_i,
  input logic             s_ready_o,
  input logic             prog_no,
  input logic             wr_strobe_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             error_o
);
  assert_bad_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (payload_len_i % LEN_W'(FRAME_BYTES)) != '0)
      |=> (error_o && !busy_o && prog_no));

  assert_no_write_prog_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !wr_strobe_o);

  assert_ready_in_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (busy_o && prog_no && !wr_strobe_o));

  assert_flags_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  assert_end_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o ^ error_o));

  assert_strobe_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o);
endmodule

bind fpga_frame_loader fpga_frame_loader_chk #(
  .LEN_W(LEN_W), .FRAME_BYTES(FRAME_BYTES)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .payload_len_i (payload_len_i),
  .s_ready_o     (s_ready_o),
  .prog_no       (prog_no),
  .wr_strobe_o   (wr_strobe_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .error_o       (error_o)
);

// File: tb/fpga_frame_loader_tb_top.sv
module fpga_frame_loader_tb_top;
  localparam int LEN_W = 20;
  localparam int HOLD  = 8;
  localparam int TMO   = 50;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [LEN_W-1:0] payload_len_i = '0;
  logic [7:0] s_data_i = '0;
  logic s_valid_i = 1'b0;
  logic s_ready_o;
  logic init_ni = 1'b1;
  logic done_i = 1'b0;
  logic prog_no;
  logic [7:0] wr_data_o;
  logic wr_strobe_o, busy_o, done_o, error_o;

  always #2.5 clk_i = ~clk_i;

  fpga_frame_loader #(
    .LEN_W(LEN_W), .FRAME_BYTES(21), .PROG_HOLD_CYC(HOLD), .INIT_TMO_CYC(TMO)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .payload_len_i(payload_len_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .init_ni(init_ni), .done_i(done_i), .prog_no(prog_no),
    .wr_data_o(wr_data_o), .wr_strobe_o(wr_strobe_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int strobe_cnt = 0, done_at = -1, drop_at = -1;
  bit init_never = 0, dropped = 0;
  int low_cnt = 0, last_low = 0, rise_dly = 0;
  bit prog_prev = 1, strobe_prev = 0, hs_pend = 0;
  int src_idx = 0, seed = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] src_byte(input int k);
    return 8'((k * 7 + seed) & 255);
  endfunction

  // scoreboard driver side
  task automatic push_hdr();
    exp_q.push_back(8'hFF); exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
    exp_q.push_back(8'h4F); exp_q.push_back(8'h80); exp_q.push_back(8'hAF);
    exp_q.push_back(8'h9B); exp_q.push_back(8'h4B);
  endtask
  task automatic push_frame(input int f);
    exp_q.push_back(8'h4F);
    for (int j = 0; j < 21; j++) exp_q.push_back(src_byte(f * 21 + j));
    exp_q.push_back(8'h4B); exp_q.push_back(8'hFF); exp_q.push_back(8'h4B);
    exp_q.push_back(8'hFF); exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
  endtask
  task automatic push_stup();
    for (int j = 0; j < 4; j++) exp_q.push_back(8'hFF);
  endtask

  // monitor, target model and stream source, all at the falling edge
  always @(negedge clk_i) begin
    cyc++;
    if (hs_pend) src_idx++;
    if (wr_strobe_o) begin
      if (exp_q.size() == 0) check(0, "R6 unexpected write", wr_data_o, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(wr_data_o == e, "R5/R6/R8 write byte", wr_data_o, e);
      end
      strobe_cnt++;
      if (strobe_prev) check(0, "R10 back-to-back strobe", 1, 0);
    end
    if (wr_strobe_o && !prog_no) check(0, "R4 write during program pulse", 1, 0);
    strobe_prev = wr_strobe_o;
    if (!prog_no) low_cnt++;
    if (prog_no && !prog_prev) begin last_low = low_cnt; low_cnt = 0; end
    prog_prev = prog_no;
    if (!prog_no) begin
      init_ni = 1'b0; done_i = 1'b0; rise_dly = 0; dropped = 0;
    end else if (!init_ni && !init_never && !dropped) begin
      rise_dly++;
      if (rise_dly >= 3) init_ni = 1'b1;
    end
    if (done_at >= 0 && strobe_cnt == done_at) done_i = 1'b1;
    if (drop_at >= 0 && strobe_cnt == drop_at) begin init_ni = 1'b0; dropped = 1; end
    s_valid_i = (cyc % 5) != 2;
    s_data_i  = src_byte(src_idx);
    hs_pend   = s_valid_i && s_ready_o;
  end

  task automatic run_load(input int len, input int d_at, input int dr_at, input bit never);
    @(negedge clk_i);
    done_at = d_at; drop_at = dr_at; init_never = never;
    src_idx = 0; strobe_cnt = 0; hs_pend = 0; seed = seed + 11;
    payload_len_i = LEN_W'(len);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    check(prog_no && !wr_strobe_o && !s_ready_o, "R1 pins in reset", prog_no, 1);
    check(!busy_o && !done_o && !error_o, "R1 flags in reset", {busy_o, done_o, error_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && prog_no, "R1 idle after reset", busy_o, 0);

    // three full records, target completes
    seed = 0;
    push_hdr(); push_frame(0); push_frame(1); push_frame(2); push_stup();
    // push uses seed after increment in run_load; rebuild with correct seed
    exp_q.delete(); seed = 11;
    push_hdr(); push_frame(0); push_frame(1); push_frame(2); push_stup();
    seed = 0;
    run_load(63, 8 + 3 * 28 + 4, -1, 0);
    check(done_o && !error_o, "R9 success flag", done_o, 1);
    check(last_low == HOLD, "R3 program pulse width", last_low, HOLD);
    check(exp_q.size() == 0, "R6 all bytes written", exp_q.size(), 0);
    check(src_idx == 63, "R6 stream bytes consumed", src_idx, 63);

    // bad length rejected
    begin
      int ll;
      ll = last_low;
      run_load(22, -1, -1, 0);
      @(negedge clk_i);
      check(error_o && !done_o && !busy_o, "R2 bad length error", error_o, 1);
      check(strobe_cnt == 0 && last_low == ll && low_cnt == 0, "R2 no pulse or write", strobe_cnt, 0);
    end

    // zero length: header and startup only
    seed = 33; push_hdr(); push_stup(); seed = 22;
    run_load(0, 12, -1, 0);
    check(done_o && !error_o, "R7 R8 zero-length success", done_o, 1);
    check(strobe_cnt == 12, "R8 header plus startup count", strobe_cnt, 12);

    // target raises done after first record: loop ends early
    seed = 44; push_hdr(); push_frame(0); push_stup(); seed = 33;
    run_load(63, 36, -1, 0);
    check(error_o && !done_o, "R7 R9 early done leaves bytes", error_o, 1);
    check(strobe_cnt == 40 && exp_q.size() == 0, "R7 stop after done", strobe_cnt, 40);

    // init drops after first record
    seed = 55; push_hdr(); push_frame(0); push_stup(); seed = 44;
    run_load(42, -1, 36, 0);
    check(error_o && !done_o, "R7 init drop error", error_o, 1);
    check(strobe_cnt == 40, "R7 stop after init drop", strobe_cnt, 40);

    // init never rises: timeout
    seed = 55;
    run_load(21, -1, -1, 1);
    check(error_o && !done_o && prog_no, "R4 init timeout", error_o, 1);
    check(strobe_cnt == 0, "R4 no write before init", strobe_cnt, 0);
    init_never = 0;

    // all bytes sent but done never rises
    seed = 77; push_hdr(); push_frame(0); push_stup(); seed = 66;
    run_load(21, -1, -1, 0);
    check(error_o && !done_o, "R9 done low at end", error_o, 1);
    check(src_idx == 21 && exp_q.size() == 0, "R6 single record", src_idx, 21);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule